// File: doc/BRIEF.md
# Function Event Notification Queue

This block holds the pending event records of a PCI host bridge and hands them, oldest first, to a consumer. Three producers feed it. The first is a hot-plug sequencer that emits fixed chains of availability events as a slot is attached or detached. The second is an error reporter that posts one fault record at a time. The third is a configure/deconfigure command port that flips a slot's configured state and answers with a completion code. Every cycle that stores at least one record also raises a one-cycle channel-report request for the surrounding channel logic.

The block keeps a per-slot function table. Each entry holds a handle, an ID and a configured bit. The table supplies the handle and ID carried by the hot-plug events, and it is searched by ID when a configure command arrives. The consumer watches a have-event flag and issues pops. Each pop is answered one cycle later with a status and a formatted response. The fields the response carries depend on the record's class.

Top module: `fn_event_queue`

## Requirements
- R1: After reset the queue is empty. `have_event` is 1 exactly when at least one record is stored. `overflow`, `chan_report`, `pop_done` and `cfg_done` are 0 after reset.
- R2: Records leave in arrival order. A pop of a non-empty queue gives `pop_done`=1 and `pop_status`=0 in the next cycle, with the oldest record on the response ports. That record is then removed.
- R3: A pop of an empty queue gives `pop_status`=1 in the next cycle. It removes nothing, and every response field including `rsp_len` reads 0. "Empty" is judged before any record stored in the same cycle.
- R4: `chan_report` is 1 for exactly one cycle after each cycle in which one or more records were stored. It stays 0 after cycles that stored nothing.
- R5: A hot-plug of slot s sets the slot handle to 0x8000_0000 OR s, sets the slot ID to s, and sets the slot's configured bit. It stores two class-2 records with that handle and ID: event code 0x0301 (reserved to standby), then 0x0302 (standby to configured).
- R6: A hot-unplug of a configured slot stores event code 0x0303 (configured to standby/reserved) and then 0x0304 (standby to reserved). An unconfigured slot stores only 0x0304. Both records are class 2 and carry the slot's old handle and ID. The unplug then zeroes the handle and ID and clears the configured bit.
- R7: An error report stores one class-1 record carrying the given event code, handle, ID, fault address and qualifier. A report in the same cycle as a hot-plug or hot-unplug is stored after that operation's records.
- R8: A configure command (`cfg_on`=1) or deconfigure command (`cfg_on`=0) answers in the next cycle with `cfg_done`=1 and a `cfg_resp` code. The code is 0x0120 when the slot is already in the requested state, which is left unchanged. It is 0x0020 when the configured bit is flipped. It is 0x09F0 when no slot matches.
- R9: A configure lookup by ID matches only slots with a non-zero handle. Empty slots hold ID 0, but they never match ID 0.
- R10: The queue holds 8 records. A record that does not fit is dropped and sets the sticky `overflow` flag, which only reset clears. Space is judged before a pop in the same cycle.
- R11: A non-empty pop response has `rsp_len` equal to 16'h2000, which is the 32-byte length with its bytes swapped. Class-2 responses read 0 on `rsp_addr` and `rsp_qual`.
- R12: When `plug_req` and `unplug_req` are both 1 in the same cycle, the plug is carried out and the unplug is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| plug_req | input | 1 | Hot-plug the slot on `hp_slot` |
| unplug_req | input | 1 | Hot-unplug the slot on `hp_slot` |
| hp_slot | input | 3 | Slot index for plug/unplug |
| err_req | input | 1 | Post an error record |
| err_pec | input | 16 | Error event code |
| err_fh | input | 32 | Error function handle |
| err_fid | input | 32 | Error function ID |
| err_addr | input | 64 | Error fault address |
| err_qual | input | 32 | Error qualifier |
| cfg_req | input | 1 | Configure/deconfigure command |
| cfg_on | input | 1 | 1 = configure, 0 = deconfigure |
| cfg_fid | input | 32 | Target function ID |
| cfg_done | output | 1 | Command answered (one cycle) |
| cfg_resp | output | 16 | Command completion code |
| pop_req | input | 1 | Remove the oldest record |
| have_event | output | 1 | Queue is non-empty |
| pop_done | output | 1 | Pop answered (one cycle) |
| pop_status | output | 1 | 0 = record returned, 1 = queue was empty |
| rsp_len | output | 16 | Byte-swapped response length |
| rsp_cls | output | 8 | Class code (1 error, 2 availability) |
| rsp_pec | output | 16 | Event code |
| rsp_fh | output | 32 | Function handle |
| rsp_fid | output | 32 | Function ID |
| rsp_addr | output | 64 | Fault address |
| rsp_qual | output | 32 | Error qualifier |
| chan_report | output | 1 | Channel-report request pulse |
| overflow | output | 1 | Sticky drop flag |

## Verification
The bench targets several corner cases, each with a distinct failure it would expose:
- Unplugging an unconfigured slot: a design that ignores the configured bit would store a spurious 0x0303 record.
- Configure lookups for ID 0 while slot 0 is empty: a design that skips the non-zero-handle test would answer 0x0020 instead of 0x09F0.
- A plug and an error report in the same cycle as a nearly full queue, which checks both lane order and the drop boundary. Wrong lane order would pop the error record ahead of 0x0301. A wrong space count would store a ninth record or clear `overflow`.
- Pops that coincide with pushes into an empty queue, where a design that judges emptiness after the push would return status 0.

// File: rtl/evq_pkg.sv
package evq_pkg;

  parameter int unsigned CLS_W  = 8;
  parameter int unsigned PEC_W  = 16;
  parameter int unsigned FH_W   = 32;
  parameter int unsigned FID_W  = 32;
  parameter int unsigned ADDR_W = 64;
  parameter int unsigned QUAL_W = 32;
  parameter int unsigned RESP_W = 16;
  parameter int unsigned LEN_W  = 16;
  parameter int unsigned VF_BIT = 31;

  localparam logic [CLS_W-1:0] CLS_ERR   = CLS_W'(1);
  localparam logic [CLS_W-1:0] CLS_AVAIL = CLS_W'(2);

  // transition codes for slot life cycle
  localparam logic [PEC_W-1:0] PEC_RES_TO_STBY    = 16'h0301;
  localparam logic [PEC_W-1:0] PEC_STBY_TO_CFG    = 16'h0302;
  localparam logic [PEC_W-1:0] PEC_CFG_TO_STBYRES = 16'h0303;
  localparam logic [PEC_W-1:0] PEC_STBY_TO_RES    = 16'h0304;

  localparam logic [RESP_W-1:0] RESP_DONE    = 16'h0020;
  localparam logic [RESP_W-1:0] RESP_NOOP    = 16'h0120;
  localparam logic [RESP_W-1:0] RESP_UNKNOWN = 16'h09F0;

  localparam logic [LEN_W-1:0] RSP_BYTES = LEN_W'(32);

  typedef struct packed {
    logic [CLS_W-1:0]  cls;
    logic [PEC_W-1:0]  pec;
    logic [FH_W-1:0]   fh;
    logic [FID_W-1:0]  fid;
    logic [ADDR_W-1:0] faddr;
    logic [QUAL_W-1:0] qual;
  } evq_rec_t;

  function automatic logic [FH_W-1:0] slot_handle(input int unsigned slot);
    return FH_W'(slot) | (FH_W'(1) << VF_BIT);
  endfunction

  function automatic evq_rec_t mk_avail(input logic [PEC_W-1:0] pec,
                                        input logic [FH_W-1:0] fh,
                                        input logic [FID_W-1:0] fid);
    evq_rec_t r;
    r       = '0;
    r.cls   = CLS_AVAIL;
    r.pec   = pec;
    r.fh    = fh;
    r.fid   = fid;
    return r;
  endfunction

  function automatic logic [LEN_W-1:0] swap16(input logic [LEN_W-1:0] v);
    return {v[7:0], v[15:8]};
  endfunction

endpackage

// File: rtl/evq_rst_sync.sv
module evq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/evq_slot_table.sv
module evq_slot_table
  import evq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hp_plug,
  input  logic              hp_unplug,
  input  logic [SLOT_W-1:0] hp_slot,
  input  logic              cfg_req,
  input  logic              cfg_on,
  input  logic [FID_W-1:0]  cfg_fid,
  output logic [FH_W-1:0]   cur_fh,
  output logic [FID_W-1:0]  cur_fid,
  output logic              cur_cfg,
  output logic              cfg_done,
  output logic [RESP_W-1:0] cfg_resp
);
  logic [FH_W-1:0]      fh_q  [NUM_SLOTS];
  logic [FH_W-1:0]      fh_d  [NUM_SLOTS];
  logic [FID_W-1:0]     fid_q [NUM_SLOTS];
  logic [FID_W-1:0]     fid_d [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] cfg_q, cfg_d;
  logic                 found;
  logic [SLOT_W-1:0]    hit;
  logic [RESP_W-1:0]    resp_d, resp_q;
  logic                 done_q;

  assign cur_fh  = fh_q[hp_slot];
  assign cur_fid = fid_q[hp_slot];
  assign cur_cfg = cfg_q[hp_slot];

  // lookup: lowest occupied slot whose ID matches
  always_comb begin
    found = 1'b0;
    hit   = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!found && fh_q[i] != '0 && fid_q[i] == cfg_fid) begin
        found = 1'b1;
        hit   = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    fh_d   = fh_q;
    fid_d  = fid_q;
    cfg_d  = cfg_q;
    resp_d = RESP_UNKNOWN;
    if (found) resp_d = (cfg_q[hit] == cfg_on) ? RESP_NOOP : RESP_DONE;
    if (cfg_req && found) cfg_d[hit] = cfg_on;
    if (hp_plug) begin
      fh_d[hp_slot]  = slot_handle(int'(hp_slot));
      fid_d[hp_slot] = FID_W'(hp_slot);
      cfg_d[hp_slot] = 1'b1;
    end else if (hp_unplug) begin
      fh_d[hp_slot]  = '0;
      fid_d[hp_slot] = '0;
      cfg_d[hp_slot] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        fh_q[i]  <= '0;
        fid_q[i] <= '0;
      end
      cfg_q  <= '0;
      done_q <= 1'b0;
      resp_q <= '0;
    end else begin
      fh_q   <= fh_d;
      fid_q  <= fid_d;
      cfg_q  <= cfg_d;
      done_q <= cfg_req;
      if (cfg_req) resp_q <= resp_d;
    end
  end

  assign cfg_done = done_q;
  assign cfg_resp = resp_q;

  // R5: a plugged slot is configured and occupied afterwards
  assert_plug_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hp_plug |=> (cfg_q[$past(hp_slot)] && fh_q[$past(hp_slot)] != '0));

  // R6: an unplugged slot is empty afterwards
  assert_unplug_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_unplug && !hp_plug) |=> (fh_q[$past(hp_slot)] == '0 && !cfg_q[$past(hp_slot)]));

  // R8: a command is answered one cycle later
  assert_cfg_answer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |=> cfg_done);
endmodule

// File: rtl/evq_fifo.sv
module evq_fifo
  import evq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LANES = 3,
  parameter int unsigned ACC_W = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      wr_vld,
  input  evq_rec_t [LANES-1:0]  wr_rec,
  input  logic                  rd_pop,
  output evq_rec_t              head_rec,
  output logic                  empty,
  output logic [ACC_W-1:0]      n_acc,
  output logic                  dropped
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  evq_rec_t           mem_q [DEPTH];
  evq_rec_t           mem_d [DEPTH];
  logic [PTR_W-1:0]   head_q, head_d, tail, idx;
  logic [CNT_W-1:0]   cnt_q, cnt_d, space, rank;
  logic               pop;

  always_comb begin
    mem_d   = mem_q;
    tail    = head_q + PTR_W'(cnt_q);
    space   = CNT_W'(DEPTH) - cnt_q;
    rank    = '0;
    dropped = 1'b0;
    idx     = '0;
    for (int l = 0; l < LANES; l++) begin
      if (wr_vld[l]) begin
        if (rank < space) begin
          idx        = tail + PTR_W'(rank);
          mem_d[idx] = wr_rec[l];
          rank       = rank + CNT_W'(1);
        end else begin
          dropped = 1'b1;
        end
      end
    end
    pop    = rd_pop && (cnt_q != '0);
    head_d = head_q + PTR_W'(pop);
    cnt_d  = cnt_q + rank - CNT_W'(pop);
    n_acc  = ACC_W'(rank);
  end

  always_ff @(posedge clk) begin
    mem_q <= mem_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head_rec = mem_q[head_q];
  assign empty    = (cnt_q == '0);

  // R10: occupancy never exceeds the depth
  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R10: a write offered to a full queue is reported as dropped
  assert_full_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(DEPTH) && wr_vld != '0) |-> dropped);

  // R3: popping an empty queue with nothing written keeps it empty
  assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && cnt_q == '0 && wr_vld == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/fn_event_queue.sv
module fn_event_queue
  import evq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              plug_req,
  input  logic              unplug_req,
  input  logic [SLOT_W-1:0] hp_slot,
  input  logic              err_req,
  input  logic [PEC_W-1:0]  err_pec,
  input  logic [FH_W-1:0]   err_fh,
  input  logic [FID_W-1:0]  err_fid,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [QUAL_W-1:0] err_qual,
  input  logic              cfg_req,
  input  logic              cfg_on,
  input  logic [FID_W-1:0]  cfg_fid,
  output logic              cfg_done,
  output logic [RESP_W-1:0] cfg_resp,
  input  logic              pop_req,
  output logic              have_event,
  output logic              pop_done,
  output logic              pop_status,
  output logic [LEN_W-1:0]  rsp_len,
  output logic [CLS_W-1:0]  rsp_cls,
  output logic [PEC_W-1:0]  rsp_pec,
  output logic [FH_W-1:0]   rsp_fh,
  output logic [FID_W-1:0]  rsp_fid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [QUAL_W-1:0] rsp_qual,
  output logic              chan_report,
  output logic              overflow
);
  localparam int unsigned LANES = 3;
  localparam int unsigned ACC_W = $clog2(LANES + 1);

  logic                   srst_n;
  logic                   do_plug, do_unplug;
  logic [FH_W-1:0]        cur_fh;
  logic [FID_W-1:0]       cur_fid;
  logic                   cur_cfg;
  logic [LANES-1:0]       lane_vld;
  evq_rec_t [LANES-1:0]   lane_rec;
  evq_rec_t               head_rec, fmt_rec;
  logic                   q_empty, dropped;
  logic [ACC_W-1:0]       n_acc;
  logic                   done_q, status_q, report_q, ovf_q;
  logic [LEN_W-1:0]       len_q;
  evq_rec_t               rsp_q;

  evq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(srst_n));

  assign do_plug   = plug_req;
  assign do_unplug = unplug_req && !plug_req;

  evq_slot_table #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_table (
    .clk(clk), .rst_n(srst_n),
    .hp_plug(do_plug), .hp_unplug(do_unplug), .hp_slot(hp_slot),
    .cfg_req(cfg_req), .cfg_on(cfg_on), .cfg_fid(cfg_fid),
    .cur_fh(cur_fh), .cur_fid(cur_fid), .cur_cfg(cur_cfg),
    .cfg_done(cfg_done), .cfg_resp(cfg_resp)
  );

  // lanes 0..1: life-cycle chain, lane 2: error reporter
  always_comb begin
    lane_vld = '0;
    lane_rec = '0;
    if (do_plug) begin
      lane_rec[0] = mk_avail(PEC_RES_TO_STBY, slot_handle(int'(hp_slot)), FID_W'(hp_slot));
      lane_rec[1] = mk_avail(PEC_STBY_TO_CFG, slot_handle(int'(hp_slot)), FID_W'(hp_slot));
      lane_vld[1:0] = 2'b11;
    end else if (do_unplug) begin
      if (cur_cfg) begin
        lane_rec[0] = mk_avail(PEC_CFG_TO_STBYRES, cur_fh, cur_fid);
        lane_rec[1] = mk_avail(PEC_STBY_TO_RES, cur_fh, cur_fid);
        lane_vld[1:0] = 2'b11;
      end else begin
        lane_rec[0] = mk_avail(PEC_STBY_TO_RES, cur_fh, cur_fid);
        lane_vld[0] = 1'b1;
      end
    end
    if (err_req) begin
      lane_rec[2].cls   = CLS_ERR;
      lane_rec[2].pec   = err_pec;
      lane_rec[2].fh    = err_fh;
      lane_rec[2].fid   = err_fid;
      lane_rec[2].faddr = err_addr;
      lane_rec[2].qual  = err_qual;
      lane_vld[2]       = 1'b1;
    end
  end

  evq_fifo #(.DEPTH(DEPTH), .LANES(LANES), .ACC_W(ACC_W)) u_fifo (
    .clk(clk), .rst_n(srst_n),
    .wr_vld(lane_vld), .wr_rec(lane_rec),
    .rd_pop(pop_req), .head_rec(head_rec), .empty(q_empty),
    .n_acc(n_acc), .dropped(dropped)
  );

  // class-dependent response layout
  always_comb begin
    fmt_rec = head_rec;
    if (head_rec.cls == CLS_AVAIL) begin
      fmt_rec.faddr = '0;
      fmt_rec.qual  = '0;
    end
    if (q_empty) fmt_rec = '0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      done_q   <= 1'b0;
      status_q <= 1'b0;
      report_q <= 1'b0;
      ovf_q    <= 1'b0;
      len_q    <= '0;
      rsp_q    <= '0;
    end else begin
      done_q   <= pop_req;
      report_q <= (n_acc != '0);
      ovf_q    <= ovf_q | dropped;
      if (pop_req) begin
        status_q <= q_empty;
        len_q    <= q_empty ? '0 : swap16(RSP_BYTES);
        rsp_q    <= fmt_rec;
      end
    end
  end

  assign have_event  = !q_empty;
  assign pop_done    = done_q;
  assign pop_status  = status_q;
  assign rsp_len     = len_q;
  assign rsp_cls     = rsp_q.cls;
  assign rsp_pec     = rsp_q.pec;
  assign rsp_fh      = rsp_q.fh;
  assign rsp_fid     = rsp_q.fid;
  assign rsp_addr    = rsp_q.faddr;
  assign rsp_qual    = rsp_q.qual;
  assign chan_report = report_q;
  assign overflow    = ovf_q;

  // R4: a stored record is followed by a report pulse, none otherwise
  assert_report_pulse_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (n_acc != '0) |=> chan_report);
  assert_report_quiet_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (n_acc == '0) |=> !chan_report);

  // R10: overflow is sticky
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!srst_n)
    overflow |=> overflow);

  // R3: an empty pop returns status 1 with blank fields
  assert_empty_resp_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (pop_req && !have_event) |=> (pop_status && rsp_len == '0 && rsp_fh == '0));

  // R2: a pop of a non-empty queue returns status 0
  assert_pop_ok_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (pop_req && have_event) |=> (pop_done && !pop_status));
endmodule

// File: tb/fn_event_queue_test.sv
module fn_event_queue_test;

  typedef struct {
    logic [7:0]  cls;
    logic [15:0] pec;
    logic [31:0] fh;
    logic [31:0] fid;
    logic [63:0] addr;
    logic [31:0] qual;
  } mrec_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        plug_req, unplug_req, err_req, cfg_req, cfg_on, pop_req;
  logic [2:0]  hp_slot;
  logic [15:0] err_pec;
  logic [31:0] err_fh, err_fid, err_qual, cfg_fid;
  logic [63:0] err_addr;
  logic        cfg_done, have_event, pop_done, pop_status, chan_report, overflow;
  logic [15:0] cfg_resp, rsp_len, rsp_pec;
  logic [7:0]  rsp_cls;
  logic [31:0] rsp_fh, rsp_fid, rsp_qual;
  logic [63:0] rsp_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  mrec_t       q[$];
  logic [31:0] m_fh [8];
  logic [31:0] m_fid[8];
  bit          m_cfg[8];
  bit          m_ovf;

  always #4 clk = ~clk;

  fn_event_queue uut (
    .clk(clk), .rst_n(rst_n),
    .plug_req(plug_req), .unplug_req(unplug_req), .hp_slot(hp_slot),
    .err_req(err_req), .err_pec(err_pec), .err_fh(err_fh), .err_fid(err_fid),
    .err_addr(err_addr), .err_qual(err_qual),
    .cfg_req(cfg_req), .cfg_on(cfg_on), .cfg_fid(cfg_fid),
    .cfg_done(cfg_done), .cfg_resp(cfg_resp),
    .pop_req(pop_req), .have_event(have_event), .pop_done(pop_done),
    .pop_status(pop_status), .rsp_len(rsp_len), .rsp_cls(rsp_cls),
    .rsp_pec(rsp_pec), .rsp_fh(rsp_fh), .rsp_fid(rsp_fid),
    .rsp_addr(rsp_addr), .rsp_qual(rsp_qual),
    .chan_report(chan_report), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    plug_req = 0; unplug_req = 0; hp_slot = 0;
    err_req = 0; err_pec = 0; err_fh = 0; err_fid = 0; err_addr = 0; err_qual = 0;
    cfg_req = 0; cfg_on = 0; cfg_fid = 0; pop_req = 0;
  endtask

  function automatic mrec_t avail(input logic [15:0] pec, input logic [31:0] fh,
                                  input logic [31:0] fid);
    mrec_t r;
    r.cls = 8'd2; r.pec = pec; r.fh = fh; r.fid = fid; r.addr = 0; r.qual = 0;
    return r;
  endfunction

  // one clock: model update from the inputs present at the edge, then compare
  task automatic step();
    mrec_t add[$];
    mrec_t front;
    bit    pre_empty;
    int    space, acc;
    bit    found;
    int    hit;
    logic [15:0] exp_resp;
    @(posedge clk);
    #1;
    pre_empty = (q.size() == 0);
    if (!pre_empty) front = q[0];
    space = 8 - q.size();
    if (plug_req) begin
      add.push_back(avail(16'h0301, 32'h8000_0000 | 32'(hp_slot), 32'(hp_slot)));
      add.push_back(avail(16'h0302, 32'h8000_0000 | 32'(hp_slot), 32'(hp_slot)));
    end else if (unplug_req) begin
      if (m_cfg[hp_slot]) add.push_back(avail(16'h0303, m_fh[hp_slot], m_fid[hp_slot]));
      add.push_back(avail(16'h0304, m_fh[hp_slot], m_fid[hp_slot]));
    end
    if (err_req) begin
      mrec_t e;
      e.cls = 8'd1; e.pec = err_pec; e.fh = err_fh; e.fid = err_fid;
      e.addr = err_addr; e.qual = err_qual;
      add.push_back(e);
    end
    acc = 0;
    foreach (add[i]) begin
      if (acc < space) begin q.push_back(add[i]); acc++; end
      else m_ovf = 1;
    end
    if (pop_req && !pre_empty) void'(q.pop_front());
    // configure command against the table as it was before this edge
    found = 0; hit = 0;
    for (int s = 0; s < 8; s++)
      if (!found && m_fh[s] != 0 && m_fid[s] == cfg_fid) begin found = 1; hit = s; end
    exp_resp = !found ? 16'h09F0 : (m_cfg[hit] == cfg_on ? 16'h0120 : 16'h0020);
    if (cfg_req && found) m_cfg[hit] = cfg_on;
    if (plug_req) begin
      m_fh[hp_slot] = 32'h8000_0000 | 32'(hp_slot); m_fid[hp_slot] = 32'(hp_slot);
      m_cfg[hp_slot] = 1;
    end else if (unplug_req) begin
      m_fh[hp_slot] = 0; m_fid[hp_slot] = 0; m_cfg[hp_slot] = 0;
    end
    chk(have_event == (q.size() != 0), "R1", "have_event", 64'(have_event), 64'(q.size() != 0));
    chk(overflow == m_ovf, "R10", "overflow", 64'(overflow), 64'(m_ovf));
    chk(chan_report == (acc > 0), "R4", "chan_report", 64'(chan_report), 64'(acc > 0));
    chk(pop_done == pop_req, "R2", "pop_done", 64'(pop_done), 64'(pop_req));
    if (pop_req) begin
      chk(pop_status == pre_empty, "R3", "pop_status", 64'(pop_status), 64'(pre_empty));
      if (pre_empty) begin
        chk(rsp_len == 0 && rsp_fh == 0 && rsp_pec == 0 && rsp_addr == 0, "R3",
            "empty fields", {rsp_len, rsp_pec, rsp_fh}, 64'd0);
      end else begin
        chk(rsp_len == 16'h2000, "R11", "rsp_len", 64'(rsp_len), 64'h2000);
        chk(rsp_cls == front.cls, "R2", "rsp_cls", 64'(rsp_cls), 64'(front.cls));
        chk(rsp_pec == front.pec, "R2", "rsp_pec", 64'(rsp_pec), 64'(front.pec));
        chk(rsp_fh == front.fh, "R2", "rsp_fh", 64'(rsp_fh), 64'(front.fh));
        chk(rsp_fid == front.fid, "R2", "rsp_fid", 64'(rsp_fid), 64'(front.fid));
        chk(rsp_addr == front.addr, "R11", "rsp_addr", rsp_addr, front.addr);
        chk(rsp_qual == front.qual, "R11", "rsp_qual", 64'(rsp_qual), 64'(front.qual));
      end
    end
    chk(cfg_done == cfg_req, "R8", "cfg_done", 64'(cfg_done), 64'(cfg_req));
    if (cfg_req)
      chk(cfg_resp == exp_resp, found ? "R8" : "R9", "cfg_resp", 64'(cfg_resp), 64'(exp_resp));
    idle_inputs();
  endtask

  task automatic do_plug(input int s);
    plug_req = 1; hp_slot = 3'(s); step();
  endtask
  task automatic do_unplug(input int s);
    unplug_req = 1; hp_slot = 3'(s); step();
  endtask
  task automatic do_cfg(input bit on, input int fid);
    cfg_req = 1; cfg_on = on; cfg_fid = 32'(fid); step();
  endtask
  task automatic do_err(input int k);
    err_req = 1; err_pec = 16'h0040 + 16'(k); err_fh = 32'h1000 + 32'(k);
    err_fid = 32'h20 + 32'(k); err_addr = 64'hDEAD_0000_0000_0000 + 64'(k);
    err_qual = 32'h0000_0800 | 32'(k); step();
  endtask
  task automatic do_pop();
    pop_req = 1; step();
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    for (int s = 0; s < 8; s++) begin m_fh[s] = 0; m_fid[s] = 0; m_cfg[s] = 0; end
    m_ovf = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    chk(!have_event && !overflow && !pop_done && !chan_report && !cfg_done, "R1",
        "reset state", {have_event, overflow, pop_done, chan_report, cfg_done}, 64'd0);

    do_pop();                         // R3 empty pop
    do_plug(3);                       // R5
    do_pop(); do_pop(); do_pop();     // R2 order, then R3
    do_plug(1); do_plug(5);
    do_cfg(0, 5);                     // R8 toggle off
    do_cfg(0, 5);                     // R8 no action
    do_cfg(1, 5);                     // R8 toggle on
    do_cfg(1, 7);                     // R9 empty slot
    do_cfg(1, 0);                     // R9 ID 0 on empty slot 0
    repeat (4) do_pop();
    do_unplug(5);                     // R6 configured
    do_cfg(0, 1);
    do_unplug(1);                     // R6 unconfigured: one record
    do_unplug(1);                     // R6 handle now zero
    do_cfg(1, 1);                     // R9 unplugged slot not found
    repeat (4) do_pop();
    do_err(1);                        // R7
    plug_req = 1; hp_slot = 3'd2;     // R7 lane order, R12 priority
    unplug_req = 1; err_req = 1; err_pec = 16'h0077; err_fh = 32'h55;
    err_fid = 32'h66; err_addr = 64'h1234_5678_9ABC_DEF0; err_qual = 32'h0800_0001;
    step();
    repeat (5) do_pop();
    // R10: fill past depth
    for (int k = 0; k < 7; k++) do_err(k);
    plug_req = 1; hp_slot = 3'd6; err_req = 1; err_pec = 16'h0099; pop_req = 1;
    step();                           // one fits, two dropped, pop frees nothing now
    do_err(9);                        // exactly fills again
    do_err(10);                       // dropped
    repeat (10) do_pop();
    do_plug(0);
    do_cfg(0, 0);                     // R9 slot 0 occupied, ID 0 matches
    repeat (3) do_pop();
    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 9);
      pop_req = ($urandom_range(0, 2) != 0);
      if (r == 0) begin plug_req = 1; hp_slot = 3'($urandom_range(0, 7)); end
      else if (r == 1) begin unplug_req = 1; hp_slot = 3'($urandom_range(0, 7)); end
      else if (r == 2) begin cfg_req = 1; cfg_on = 1'($urandom_range(0, 1));
                             cfg_fid = 32'($urandom_range(0, 8)); end
      if ($urandom_range(0, 3) == 0) begin
        err_req = 1; err_pec = 16'($urandom); err_fh = $urandom; err_fid = $urandom;
        err_addr = {$urandom, $urandom}; err_qual = $urandom;
      end
      step();
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule